// File: doc/BRIEF.md
# PLL Divider Search Engine

This block turns a requested clock frequency into divider settings for a video PLL whose output is `8 * ref * m / n`, divided down by `2^p`. The caller supplies four values, all unsigned and in one shared frequency unit: a reference frequency, a requested frequency, and lower and upper limits on the output. The caller then pulses `start`. The engine returns three things:

- encoded codes for the feedback divider `m`, the input divider `n` and the post-divider exponent `p`;
- the output frequency those settings actually give;
- a `done` pulse when the result is ready.

The search has three stages:

- **Post-divider.** The engine first limits the request to the allowed range. It then picks the post-divider by doubling the target until the VCO reaches its floor.
- **Step.** A serial divider computes one fixed-point step, `vco / (8 * ref)`.
- **Scan.** The engine walks the input divider `n` from 3 to 25, one candidate per clock. It adds the step to an accumulator at each candidate, so the accumulator always holds the ideal feedback value for the current `n`. The candidate whose ideal value is closest to an integer from below wins.

A second pass through the same serial divider produces the achieved frequency. No floating point is used anywhere.

Top module: `pll_div_search`

## Requirements
- R1: The request is first raised to `min_freq` if below it. The result is then lowered to `max_freq` if above it, so `max_freq` wins when the limits are crossed.
- R2: `p` is the smallest value in 0..3 for which the limited request times `2^p` is at least `VCO_FLOOR` (default 110000). If no value in that range reaches the floor, `p` is 3. That product is the VCO value.
- R3: The step is `floor(vco * 2^FRAC / (8 * ref))`, with `FRAC` = 16. The candidate `n = 3` sees three steps, and each later candidate sees one step more. When `ref` is 0, the step is all ones.
- R4: A candidate is usable only when its accumulated value lies in [3.0, 64.0]. A value of 64 with a non-zero fraction is rejected.
- R5: The usable candidate with the smallest fraction (the low `FRAC` bits) wins. Only a strictly smaller fraction replaces the current best, so on a tie the smaller `n` is kept.
- R6: The codes are computed as follows:
  - `m_code = 65 - m`, where `m` is the integer part of the winner;
  - `n_code = 65 - n`;
  - `p_code = p`.
- R7: `out_freq = floor(8 * ref * m / n) >> p`.
- R8: `done` is high for exactly one cycle per accepted `start`. All result outputs change only in a cycle where `done` is high, and they hold their values otherwise.
- R9: A `start` that arrives while a search is running has no effect: no extra `done`, and the running result is unchanged.
- R10: When no candidate is usable, the engine reports:
  - `no_fit = 1`;
  - `m_code = 0`, `n_code = 0` and `out_freq = 0`;
  - `p_code` still holds `p`.
- R11: While `rst_n` is low, every output is 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; sampled only when idle |
| ref_freq | input | FW | Reference frequency |
| req_freq | input | FW | Requested output frequency |
| min_freq | input | FW | Lowest allowed output |
| max_freq | input | FW | Highest allowed output |
| m_code | output | 6 | Feedback divider code, 65 - m |
| n_code | output | 6 | Input divider code, 65 - n |
| p_code | output | 2 | Post-divider exponent |
| out_freq | output | FW+8 | Achieved output frequency |
| done | output | 1 | One-cycle result strobe |
| no_fit | output | 1 | No usable candidate found |

## Verification
The clamp assertions assume `min_freq <= max_freq` only where they claim the result lies inside the range. The stimulus keeps every vector ordered that way.

The divider exactness check assumes a non-zero divisor. A zero reference is therefore driven only to exercise the no-fit path, where that check is excluded.

The assertions also assume the request inputs are stable in the `start` cycle, because the prescale stage is sampled only there. The bench changes inputs only while the engine is busy, to prove they are ignored.

// File: rtl/pll_search_pkg.sv
// Shared constants and the phase type for the PLL divider search engine.
// Assumes the candidate window and code base are fixed by the PLL topology.
package pll_search_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIV_STEP,
        PH_SCAN,
        PH_PICK,
        PH_DIV_FREQ
    } phase_t;

    localparam int N_FIRST   = 3;
    localparam int N_LAST    = 25;
    localparam int FB_LOW    = 3;
    localparam int FB_HIGH   = 64;
    localparam int CODE_BASE = 65;
    localparam int P_LIMIT   = 3;
    localparam int PW        = $clog2(P_LIMIT + 1);
    localparam int NCW       = $clog2(N_LAST + 1);
    localparam int MW        = $clog2(FB_HIGH + 1);
    localparam int CMW       = 6;
endpackage

// File: rtl/pll_prescale.sv
// Limits the request to the allowed range, then doubles it until it reaches
// the VCO floor, at most P_LIMIT times. Purely combinational.
// Assumes VCO_FLOOR fits in FW bits, so one doubling never overflows FW+1 bits.
module pll_prescale
    import pll_search_pkg::*;
#(
    parameter int FW        = 24,
    parameter int VCO_FLOOR = 110000
) (
    input  logic [FW-1:0] req,
    input  logic [FW-1:0] lo,
    input  logic [FW-1:0] hi,
    output logic [FW-1:0] clamped,
    output logic [FW:0]   vco,
    output logic [PW-1:0] p
);
    localparam int VW = FW + 1;

    // Clamp (low bound first, then high bound), then select the exponent.
    always_comb begin
        clamped = req;
        if (req < lo) clamped = lo;
        if (clamped > hi) clamped = hi;
        vco = {1'b0, clamped};
        p   = '0;
        for (int i = 0; i < P_LIMIT; i++) begin
            if (vco < VW'(VCO_FLOOR)) begin
                vco = vco << 1;
                p   = p + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pll_serdiv.sv
// Restoring serial divider: one quotient bit per clock, NW clocks per divide.
// Assumes start is raised only when the divider is idle. A zero divisor
// yields an all-ones quotient.
module pll_serdiv #(
    parameter int NW = 41,
    parameter int DW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quot,
    output logic          done
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] q_r, num_r;
    logic [DW-1:0] rem_r, den_r;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   trial, diff;
    logic          ge;
    logic [NW+DW-1:0] recon;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem_r, q_r[NW-1]};
        diff  = trial - {1'b0, den_r};
        ge    = (trial >= {1'b0, den_r});
        recon = (NW+DW)'(q_r) * (NW+DW)'(den_r) + (NW+DW)'(rem_r);
    end

    // Shift-subtract sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            num_r <= '0;
            rem_r <= '0;
            den_r <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                q_r   <= num;
                num_r <= num;
                den_r <= den;
                rem_r <= '0;
                cnt   <= CW'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                q_r   <= {q_r[NW-2:0], ge};
                rem_r <= ge ? diff[DW-1:0] : trial[DW-1:0];
                cnt   <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;

    // R3 / R7: a finished divide reconstructs its dividend exactly.
    a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_r != '0) |-> (recon == (NW+DW)'(num_r) && rem_r < den_r));
endmodule

// File: rtl/pll_cand_pick.sv
// Judges one candidate: is its accumulated feedback value inside the usable
// window, and is its fraction strictly below the best seen so far?
// Assumes acc holds FRAC fraction bits.
module pll_cand_pick
    import pll_search_pkg::*;
#(
    parameter int AC   = 46,
    parameter int FRAC = 16
) (
    input  logic [AC-1:0]   acc,
    input  logic [FRAC:0]   best_err,
    output logic            take,
    output logic [MW-1:0]   cand_m,
    output logic [FRAC-1:0] cand_frac
);
    localparam logic [AC-1:0] LOW_BOUND  = AC'(FB_LOW) << FRAC;
    localparam logic [AC-1:0] HIGH_BOUND = AC'(FB_HIGH) << FRAC;

    logic in_window;

    // Window test and strict fraction comparison.
    always_comb begin
        in_window = (acc >= LOW_BOUND) && (acc <= HIGH_BOUND);
        cand_frac = acc[FRAC-1:0];
        cand_m    = acc[FRAC+MW-1:FRAC];
        take      = in_window && ({1'b0, cand_frac} < best_err);
    end
endmodule

// File: rtl/pll_div_search.sv
// PLL divider search engine. On start it latches the inputs and prescales
// the request. It then divides out a fixed-point step, scans n = 3..25 one
// per clock, and divides again for the achieved frequency.
// Assumes inputs are valid in the start cycle; later input changes are ignored.
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FW        = 24,
    parameter int FRAC      = 16,
    parameter int VCO_FLOOR = 110000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FW-1:0]   ref_freq,
    input  logic [FW-1:0]   req_freq,
    input  logic [FW-1:0]   min_freq,
    input  logic [FW-1:0]   max_freq,
    output logic [5:0]      m_code,
    output logic [5:0]      n_code,
    output logic [1:0]      p_code,
    output logic [FW+7:0]   out_freq,
    output logic            done,
    output logic            no_fit
);
    localparam int VW = FW + 1;
    localparam int NW = VW + FRAC;
    localparam int DW = FW + 3;
    localparam int AW = FW + 8;
    localparam int AC = NW + 5;
    localparam logic [FRAC:0] ERR_INIT = (FRAC+1)'(1) << FRAC;

    phase_t           st;
    logic [FW-1:0]    ref_q;
    logic [PW-1:0]    p_q;
    logic [NW-1:0]    inc_q;
    logic [AC-1:0]    acc_q;
    logic [NCW-1:0]   n_q;
    logic [MW-1:0]    best_m;
    logic [NCW-1:0]   best_n;
    logic [FRAC:0]    err_best;

    logic [FW-1:0]    pre_clamp;
    logic [VW-1:0]    pre_vco;
    logic [PW-1:0]    pre_p;
    logic             take;
    logic [MW-1:0]    cand_m;
    logic [FRAC-1:0]  cand_frac;
    logic             div_start, div_done;
    logic [NW-1:0]    div_num, div_quot;
    logic [DW-1:0]    div_den;
    logic [DW+MW-1:0] freq_prod;

    pll_prescale #(.FW(FW), .VCO_FLOOR(VCO_FLOOR)) u_pre (
        .req(req_freq), .lo(min_freq), .hi(max_freq),
        .clamped(pre_clamp), .vco(pre_vco), .p(pre_p)
    );

    pll_cand_pick #(.AC(AC), .FRAC(FRAC)) u_pick (
        .acc(acc_q), .best_err(err_best),
        .take(take), .cand_m(cand_m), .cand_frac(cand_frac)
    );

    pll_serdiv #(.NW(NW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .quot(div_quot), .done(div_done)
    );

    // Divider operand selection: step division when idle, frequency otherwise.
    always_comb begin
        freq_prod = {ref_q, 3'b000} * best_m;
        div_start = (st == PH_IDLE && start) || (st == PH_PICK && best_m != '0);
        if (st == PH_IDLE) begin
            div_num = {pre_vco, {FRAC{1'b0}}};
            div_den = {ref_freq, 3'b000};
        end else begin
            div_num = NW'(freq_prod);
            div_den = DW'(best_n);
        end
    end

    // Search sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PH_IDLE;
            ref_q    <= '0;
            p_q      <= '0;
            inc_q    <= '0;
            acc_q    <= '0;
            n_q      <= '0;
            best_m   <= '0;
            best_n   <= '0;
            err_best <= '0;
            m_code   <= '0;
            n_code   <= '0;
            p_code   <= '0;
            out_freq <= '0;
            done     <= 1'b0;
            no_fit   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                PH_IDLE: if (start) begin
                    ref_q <= ref_freq;
                    p_q   <= pre_p;
                    st    <= PH_DIV_STEP;
                end
                PH_DIV_STEP: if (div_done) begin
                    inc_q    <= div_quot;
                    acc_q    <= AC'(div_quot) + (AC'(div_quot) << 1);
                    n_q      <= NCW'(N_FIRST);
                    best_m   <= '0;
                    best_n   <= '0;
                    err_best <= ERR_INIT;
                    st       <= PH_SCAN;
                end
                PH_SCAN: begin
                    if (take) begin
                        best_m   <= cand_m;
                        best_n   <= n_q;
                        err_best <= {1'b0, cand_frac};
                    end
                    acc_q <= acc_q + AC'(inc_q);
                    n_q   <= n_q + 1'b1;
                    if (n_q == NCW'(N_LAST)) st <= PH_PICK;
                end
                PH_PICK: begin
                    if (best_m == '0) begin
                        m_code   <= '0;
                        n_code   <= '0;
                        p_code   <= p_q;
                        out_freq <= '0;
                        no_fit   <= 1'b1;
                        done     <= 1'b1;
                        st       <= PH_IDLE;
                    end else begin
                        st <= PH_DIV_FREQ;
                    end
                end
                PH_DIV_FREQ: if (div_done) begin
                    m_code   <= CMW'(MW'(CODE_BASE) - best_m);
                    n_code   <= CMW'(MW'(CODE_BASE) - MW'(best_n));
                    p_code   <= p_q;
                    out_freq <= AW'(div_quot >> p_q);
                    no_fit   <= 1'b0;
                    done     <= 1'b1;
                    st       <= PH_IDLE;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    a_r1_clamp_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && start && min_freq <= max_freq)
        |-> (pre_clamp >= min_freq && pre_clamp <= max_freq));
    a_r1_clamp_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && start && req_freq >= min_freq && req_freq <= max_freq)
        |-> pre_clamp == req_freq);
    a_r2_vco_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && start && pre_p != PW'(P_LIMIT)) |-> pre_vco >= VW'(VCO_FLOOR));
    a_r2_p_minimal: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && start && pre_p != '0)
        |-> ({1'b0, pre_vco} < (VW+1)'(2 * VCO_FLOOR)));
    a_r4_take_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_SCAN && take) |-> (cand_m >= MW'(FB_LOW) && cand_m <= MW'(FB_HIGH)));
    a_r5_err_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_SCAN) |=> (err_best <= $past(err_best)));
    a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (m_code >= 6'd1 && m_code <= 6'd62 &&
                               n_code >= 6'd40 && n_code <= 6'd62));
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(m_code) || !$stable(n_code) || !$stable(p_code) ||
         !$stable(out_freq) || !$stable(no_fit)) |-> done);
    a_r9_scan_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_SCAN) |=> (st == PH_SCAN || st == PH_PICK));
    a_r10_nofit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_fit) |-> (m_code == '0 && n_code == '0 && out_freq == '0));
endmodule

// File: tb/tb_pll_div_search.sv
`timescale 1ns/1ps
module tb_pll_div_search;
    localparam int FW = 24;
    localparam int FRAC = 16;
    localparam int VCO_FLOOR = 110000;
    localparam int NV = 12;
    localparam longint V_REF [NV] = '{14318, 14318, 14318, 27000, 14318, 14318,
                                      50000, 100000, 1, 0, 400000, 10000};
    localparam longint V_REQ [NV] = '{25175, 65000, 135000, 108000, 5000, 300000,
                                      110000, 109999, 200000, 150000, 110000, 160000};
    localparam longint V_LO = 12000;
    localparam longint V_HI = 220000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FW-1:0] ref_freq = '0, req_freq = '0, min_freq = '0, max_freq = '0;
    logic [5:0] m_code, n_code;
    logic [1:0] p_code;
    logic [FW+7:0] out_freq;
    logic done, no_fit;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;

    pll_div_search #(.FW(FW), .FRAC(FRAC), .VCO_FLOOR(VCO_FLOOR)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_freq(ref_freq), .req_freq(req_freq), .min_freq(min_freq), .max_freq(max_freq),
        .m_code(m_code), .n_code(n_code), .p_code(p_code),
        .out_freq(out_freq), .done(done), .no_fit(no_fit)
    );

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n && done) done_seen++;

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected result computed from the requirements.
    function automatic void model(input longint rf, input longint rq, input longint lo,
                                  input longint hi, output longint em, output longint en,
                                  output longint ep, output longint ef, output bit ee);
        longint t, v, d, inc, acc, err, bm, bn, ip, fr;
        t = rq;
        if (t < lo) t = lo;                      // R1
        if (t > hi) t = hi;
        v = t; ep = 0;
        while (ep < 3 && v < VCO_FLOOR) begin v = v * 2; ep++; end   // R2
        d = 8 * rf;
        inc = (d == 0) ? ((64'd1 << (FW + 1 + FRAC)) - 1) : ((v << FRAC) / d);  // R3
        acc = 3 * inc; err = 64'd1 << FRAC; bm = 0; bn = 0;
        for (int k = 3; k <= 25; k++) begin
            ip = acc >> FRAC;
            fr = acc & ((64'd1 << FRAC) - 1);
            if (ip >= 3 && acc <= (64'd64 << FRAC) && fr < err) begin   // R4, R5
                err = fr; bm = ip; bn = k;
            end
            acc = acc + inc;
        end
        if (bm == 0) begin
            ee = 1; em = 0; en = 0; ef = 0;      // R10
        end else begin
            ee = 0; em = 65 - bm; en = 65 - bn;  // R6
            ef = ((8 * rf * bm) / bn) >> ep;     // R7
        end
    endfunction

    task automatic launch(input longint rf, input longint rq);
        @(negedge clk);
        ref_freq = FW'(rf); req_freq = FW'(rq);
        min_freq = FW'(V_LO); max_freq = FW'(V_HI);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 400 && !seen; c++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
    endtask

    task automatic check_result(input longint rf, input longint rq, input string tag);
        longint em, en, ep, ef;
        bit ee;
        model(rf, rq, V_LO, V_HI, em, en, ep, ef, ee);
        chk(m_code == 6'(em), {tag, " R6 m_code"}, m_code, em);
        chk(n_code == 6'(en), {tag, " R6 n_code"}, n_code, en);
        chk(p_code == 2'(ep), {tag, " R2 p_code"}, p_code, ep);
        chk(out_freq == 32'(ef), {tag, " R7 out_freq"}, out_freq, ef);
        chk(no_fit == ee, {tag, " R10 no_fit"}, no_fit, ee);
    endtask

    initial begin
        bit seen;
        int base;
        logic [5:0] hold_m;
        logic [31:0] hold_f;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(done == 1'b0 && no_fit == 1'b0, "R11 flags", {done, no_fit}, 0);
        chk(m_code == '0 && n_code == '0 && p_code == '0 && out_freq == '0,
            "R11 results", out_freq, 0);
        rst_n = 1'b1;

        // Vector table: clamps (R1), exponents (R2), zero/huge ref (R3, R10), tie (R5)
        for (int i = 0; i < NV; i++) begin
            launch(V_REF[i], V_REQ[i]);
            wait_done(seen);
            chk(seen, "R8 done arrives", seen, 1);
            check_result(V_REF[i], V_REQ[i], $sformatf("vec%0d", i));
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", done, 0);
        end

        // R5: exact step of 2.0 gives ties; the first n=3 must be kept
        chk(m_code == 6'd59 && n_code == 6'd62, "R5 tie keeps n=3", {m_code, n_code}, {6'd59, 6'd62});
        chk(out_freq == 32'd160000, "R7 exact tie freq", out_freq, 160000);

        // R8: outputs hold while idle
        hold_m = m_code; hold_f = out_freq;
        repeat (20) @(negedge clk);
        chk(m_code == hold_m && out_freq == hold_f, "R8 hold", out_freq, hold_f);

        // R9: a second start while busy is ignored
        base = done_seen;
        launch(V_REF[11], V_REQ[11]);
        repeat (50) @(negedge clk);
        ref_freq = FW'(V_REF[0]); req_freq = FW'(V_REQ[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen, "R9 done arrives", seen, 1);
        check_result(V_REF[11], V_REQ[11], "busy");
        repeat (150) @(negedge clk);
        chk(done_seen == base + 1, "R9 single done", done_seen - base, 1);

        // R11: reset clears results
        rst_n = 1'b0;
        @(negedge clk);
        chk(m_code == '0 && out_freq == '0 && done == 1'b0, "R11 reset again", out_freq, 0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule